// File: doc/BRIEF.md
# Flash Program Line Gatherer

This block sits between a bus that issues 32-bit word writes into the flash address space and the program port of a flash array. The array programs one wide line at a time, so the block gathers word writes into a line buffer, a 256-bit flash word by default. It then hands the whole line to the array in a single request.

A line is committed in one of two ways. It goes when the last empty slot is filled, in any order. It also goes earlier when software issues a force-write, and then every slot that was never written goes out as all ones, the erased value. Data writes count only while the program-enable control bit is held high. A write made without that bit, or one that strays into a different line while a line is half full, is flagged with a one-cycle error pulse. The array's program time is modelled by a countdown that holds the busy flag high. A data write that arrives during that time is stalled until the countdown ends.

Top module: `pwb_top`

## Requirements
- R1: The write address `wrAddr` is a word address. Its low log2(WORDS) bits select the slot inside a line and its upper bits select the line. A line commits when its last empty slot is written, whatever order the slots were filled in. The line index of the commit appears on `arrayLine`.
- R2: A commit raises `arrayReq` for exactly one cycle, in the cycle after the clock edge that accepted the completing write or force. `arrayData` holds slot i in bits [i*WORD_W +: WORD_W].
- R3: `busy` goes high in the same cycle as `arrayReq` and stays high for exactly PROG_CYCLES cycles.
- R4: A force-write (`forceWr` high) commits a partly filled line while `progEn` is high and the block is not busy. Every slot not written since the last commit or discard is sent as all ones.
- R5: A force-write is ignored, with no `arrayReq` and no change to the buffer, when `progEn` is low or when the buffer is empty.
- R6: A data write accepted while `progEn` is low raises `seqErr` for one cycle in the next cycle. The write is dropped, so its slot stays unwritten.
- R7: While a line is partly filled, a write to a different line raises `incErr` for one cycle in the next cycle. That write is dropped and the partial line is discarded, so a later force-write on an empty buffer does nothing.
- R8: A data write presented while `busy` is high sees `wrStall` high and is not taken. It is accepted on the first edge after `busy` falls.
- R9: After reset `busy`, `wrStall`, `arrayReq`, `seqErr` and `incErr` are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| progEn | input | 1 | Program-enable bit from the control register |
| forceWr | input | 1 | Force-write command, one-cycle strobe |
| wrValid | input | 1 | Data write request |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | WORD_W | Write data |
| wrStall | output | 1 | Write held off because the array is busy |
| busy | output | 1 | A line is being programmed |
| seqErr | output | 1 | Programming-sequence error pulse |
| incErr | output | 1 | Address-increment error pulse |
| arrayReq | output | 1 | Program request to the array, one cycle |
| arrayLine | output | ADDR_W-log2(WORDS) | Line index of the request |
| arrayData | output | WORDS*WORD_W | Line contents of the request |

## Verification
The bench builds the block with eight 32-bit slots, a 12-bit word address and PROG_CYCLES set to 6. The full 256-bit line, its ordering and its padding are therefore exercised at their real size. The short countdown brings the stall window and the exact busy length within a few cycles. The address width leaves room for several distinct lines, so line changes, discards and line indices on the array port can all be observed.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic store;   // write wrData into the addressed slot
    logic clear;   // refill all slots with the erased value
    logic commit;  // issue the line to the array
  } pwbStrobe_t;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WORDS       = 8,
  parameter int PROG_CYCLES = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       progEn,
  input  logic                       forceWr,
  input  logic                       wrValid,
  input  logic [ADDR_W-1:0]          wrAddr,
  output pwbStrobe_t                 strobe,
  output logic [$clog2(WORDS)-1:0]   slotIdx,
  output logic [ADDR_W-$clog2(WORDS)-1:0] commitLine,
  output logic                       wrStall,
  output logic                       busy,
  output logic                       seqErr,
  output logic                       incErr
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - IDX_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  logic [WORDS-1:0]  maskQ, nextMask;
  logic [LINE_W-1:0] lineTag, writeLine;
  logic [CNT_W-1:0]  cntQ;
  logic accept, lineMiss, seqHit, incHit, storeHit, forceGo, commitGo;

  assign busy      = cntQ != '0;
  assign wrStall   = wrValid && busy;
  assign accept    = wrValid && !busy;
  assign writeLine = wrAddr[ADDR_W-1:IDX_W];
  assign slotIdx   = wrAddr[IDX_W-1:0];
  assign lineMiss  = (|maskQ) && (writeLine != lineTag);

  assign seqHit   = accept && !progEn;
  assign incHit   = accept && progEn && lineMiss;
  assign storeHit = accept && progEn && !lineMiss;
  assign nextMask = maskQ | (storeHit ? (WORDS'(1) << slotIdx) : '0);
  assign forceGo  = forceWr && progEn && !busy && (|nextMask) && !incHit;
  assign commitGo = (storeHit && (&nextMask)) || forceGo;

  assign strobe.store  = storeHit;
  assign strobe.clear  = commitGo || incHit;
  assign strobe.commit = commitGo;
  assign commitLine    = storeHit ? writeLine : lineTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      lineTag <= '0;
      cntQ    <= '0;
      seqErr  <= 1'b0;
      incErr  <= 1'b0;
    end else begin
      maskQ  <= strobe.clear ? '0 : nextMask;
      if (storeHit) lineTag <= writeLine;
      if (commitGo)  cntQ <= CNT_W'(PROG_CYCLES);
      else if (busy) cntQ <= cntQ - CNT_W'(1);
      seqErr <= seqHit;
      incErr <= incHit;
    end
  end

  // R8
  idle_buffer_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> maskQ == '0);
  // R7
  discard_on_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    incErr |-> maskQ == '0);
  // R6
  single_error_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(seqErr && incErr));
  // R3
  countdown_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(PROG_CYCLES));
endmodule

// File: rtl/pwb_data.sv
module pwb_data
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 8,
  parameter int WORD_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  pwbStrobe_t                      strobe,
  input  logic [$clog2(WORDS)-1:0]        slotIdx,
  input  logic [WORD_W-1:0]               wrData,
  input  logic [ADDR_W-$clog2(WORDS)-1:0] commitLine,
  output logic                            arrayReq,
  output logic [ADDR_W-$clog2(WORDS)-1:0] arrayLine,
  output logic [WORDS*WORD_W-1:0]         arrayData
);
  localparam int IDX_W = $clog2(WORDS);

  logic [WORDS-1:0][WORD_W-1:0] slotQ, slotNext;

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    assign slotNext[g] = (strobe.store && slotIdx == IDX_W'(g)) ? wrData : slotQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ     <= '1;
      arrayReq  <= 1'b0;
      arrayLine <= '0;
      arrayData <= '0;
    end else begin
      slotQ    <= strobe.clear ? '1 : slotNext;
      arrayReq <= strobe.commit;
      if (strobe.commit) begin
        arrayLine <= commitLine;
        arrayData <= slotNext;
      end
    end
  end

  // R2
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrayReq |=> !arrayReq);
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WORDS       = 8,
  parameter int WORD_W      = 32,
  parameter int PROG_CYCLES = 64
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            progEn,
  input  logic                            forceWr,
  input  logic                            wrValid,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic [WORD_W-1:0]               wrData,
  output logic                            wrStall,
  output logic                            busy,
  output logic                            seqErr,
  output logic                            incErr,
  output logic                            arrayReq,
  output logic [ADDR_W-$clog2(WORDS)-1:0] arrayLine,
  output logic [WORDS*WORD_W-1:0]         arrayData
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - IDX_W;

  pwbStrobe_t        strobe;
  logic [IDX_W-1:0]  slotIdx;
  logic [LINE_W-1:0] commitLine;

  pwb_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .progEn(progEn), .forceWr(forceWr),
    .wrValid(wrValid), .wrAddr(wrAddr), .strobe(strobe), .slotIdx(slotIdx),
    .commitLine(commitLine), .wrStall(wrStall), .busy(busy),
    .seqErr(seqErr), .incErr(incErr));

  pwb_data #(.ADDR_W(ADDR_W), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx),
    .wrData(wrData), .commitLine(commitLine), .arrayReq(arrayReq),
    .arrayLine(arrayLine), .arrayData(arrayData));

  // R3
  req_implies_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrayReq |-> busy);
  // R6
  seq_err_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> !arrayReq);
endmodule

// File: tb/tb_pwb_top.sv
module tb_pwb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 12;
  localparam int WORDS       = 8;
  localparam int WORD_W      = 32;
  localparam int PROG_CYCLES = 6;
  localparam int IDX_W       = $clog2(WORDS);
  localparam int LINE_W      = ADDR_W - IDX_W;
  localparam int DATA_W      = WORDS * WORD_W;

  logic clk = 1'b0, rstN = 1'b0, progEn = 1'b0, forceWr = 1'b0, wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [WORD_W-1:0] wrData = '0;
  logic wrStall, busy, seqErr, incErr, arrayReq;
  logic [LINE_W-1:0] arrayLine;
  logic [DATA_W-1:0] arrayData;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [LINE_W+DATA_W-1:0] expQ[$];
  logic [WORD_W-1:0] expSlot[WORDS];
  int stallSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_top #(.ADDR_W(ADDR_W), .WORDS(WORDS), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .progEn(progEn), .forceWr(forceWr), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .wrStall(wrStall), .busy(busy),
    .seqErr(seqErr), .incErr(incErr), .arrayReq(arrayReq),
    .arrayLine(arrayLine), .arrayData(arrayData));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] pat(input int line, input int idx);
    return WORD_W'(32'hA5000000 + (line << 8) + idx);
  endfunction

  task automatic clearExp();
    for (int i = 0; i < WORDS; i++) expSlot[i] = '1;
  endtask

  task automatic pushExp(input int line);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < WORDS; i++) d[i*WORD_W +: WORD_W] = expSlot[i];
    expQ.push_back({LINE_W'(line), d});
    clearExp();
  endtask

  // drive one write; returns at the negedge after acceptance
  task automatic doWrite(input int line, input int idx, input logic [WORD_W-1:0] d);
    stallSeen = 0;
    @(negedge clk);
    wrValid = 1'b1; wrAddr = {LINE_W'(line), IDX_W'(idx)}; wrData = d;
    #1;
    while (wrStall) begin stallSeen++; @(negedge clk); #1; end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic doForce();
    @(negedge clk); forceWr = 1'b1;
    @(negedge clk); forceWr = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    int cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == PROG_CYCLES, req, "busy length", 64'(cnt), 64'(PROG_CYCLES));
  endtask

  // monitor: compare every array request against the scoreboard
  always @(negedge clk) begin
    if (rstN && arrayReq) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected request actual=line %0h expected=none", arrayLine);
      end else begin
        logic [LINE_W+DATA_W-1:0] e;
        e = expQ.pop_front();
        if ({arrayLine, arrayData} !== e) begin
          failures++;
          $display("FAIL R1/R4 request actual=%0h_%0h expected=%0h_%0h",
                   arrayLine, arrayData, e[LINE_W+DATA_W-1:DATA_W], e[DATA_W-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clearExp();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !wrStall && !arrayReq && !seqErr && !incErr, "R9", "reset outputs",
        {busy, wrStall, arrayReq, seqErr, incErr}, 0);
    rstN = 1'b1;
    progEn = 1'b1;

    // R1 in-order fill of line 3, R2 pulse, R3 busy length
    for (int i = 0; i < WORDS; i++) begin
      expSlot[i] = pat(3, i);
      if (i == WORDS-1) pushExp(3);
      doWrite(3, i, pat(3, i));
    end
    chk(arrayReq == 1'b1, "R2", "request after last slot", 64'(arrayReq), 1);
    waitIdle("R3");
    chk(arrayReq == 1'b0, "R2", "request single cycle", 64'(arrayReq), 0);

    // R1 reverse order fill of line 5
    for (int i = WORDS-1; i >= 0; i--) begin
      expSlot[i] = pat(5, i);
      if (i == 0) pushExp(5);
      doWrite(5, i, pat(5, i));
    end
    chk(arrayReq == 1'b1, "R1", "reverse order commit", 64'(arrayReq), 1);
    waitIdle("R3");

    // R4 partial line with force, padding with ones
    doWrite(6, 0, pat(6, 0)); expSlot[0] = pat(6, 0);
    doWrite(6, 2, pat(6, 2)); expSlot[2] = pat(6, 2);
    doWrite(6, 5, pat(6, 5)); expSlot[5] = pat(6, 5);
    chk(arrayReq == 1'b0, "R4", "no commit before force", 64'(arrayReq), 0);
    pushExp(6);
    doForce();
    chk(arrayReq == 1'b1, "R4", "force commit", 64'(arrayReq), 1);
    waitIdle("R3");

    // R5 force on empty buffer
    doForce();
    chk(arrayReq == 1'b0 && !busy, "R5", "force on empty buffer", 64'(arrayReq), 0);

    // R6 write without program-enable is dropped
    progEn = 1'b0;
    doWrite(8, 0, 32'hDEADBEEF);
    chk(seqErr == 1'b1, "R6", "seqErr pulse", 64'(seqErr), 1);
    @(negedge clk);
    chk(seqErr == 1'b0, "R6", "seqErr one cycle", 64'(seqErr), 0);
    progEn = 1'b1;
    doWrite(8, 1, pat(8, 1)); expSlot[1] = pat(8, 1);
    // R5 force with program-enable low is ignored
    progEn = 1'b0;
    doForce();
    chk(arrayReq == 1'b0, "R5", "force with progEn low", 64'(arrayReq), 0);
    progEn = 1'b1;
    pushExp(8);
    doForce();
    chk(arrayReq == 1'b1, "R6", "commit without dropped slot", 64'(arrayReq), 1);
    waitIdle("R3");

    // R7 line change discards partial line
    doWrite(7, 0, pat(7, 0));
    doWrite(7, 1, pat(7, 1));
    doWrite(9, 2, pat(9, 2));
    chk(incErr == 1'b1 && arrayReq == 1'b0, "R7", "incErr pulse", {incErr, arrayReq}, 2'b10);
    doForce();
    chk(arrayReq == 1'b0 && !busy, "R7", "buffer discarded", 64'(arrayReq), 0);
    doWrite(9, 4, pat(9, 4)); expSlot[4] = pat(9, 4);
    pushExp(9);
    doForce();
    chk(arrayReq == 1'b1 && incErr == 1'b0, "R7", "fresh line commit", {arrayReq, incErr}, 2'b10);
    waitIdle("R3");

    // R8 write during busy is stalled, then accepted
    for (int i = 0; i < WORDS; i++) begin
      expSlot[i] = pat(2, i);
      if (i == WORDS-1) pushExp(2);
      doWrite(2, i, pat(2, i));
    end
    doWrite(4, 6, pat(4, 6)); expSlot[6] = pat(4, 6);
    chk(stallSeen > 0, "R8", "stall observed", 64'(stallSeen), 64'(PROG_CYCLES-1));
    chk(!busy, "R8", "accepted after busy", 64'(busy), 0);
    pushExp(4);
    doForce();
    chk(arrayReq == 1'b1, "R8", "held word committed", 64'(arrayReq), 1);
    waitIdle("R3");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2", "all requests seen", 64'(expQ.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule